// File: doc/BRIEF.md
# Blocking Cache Miss Buffer

This controller sits beside a blocking cache and holds the cache's traffic toward memory. It has two storage slots: a miss slot for reads and allocating writes, and a writeback slot for writes that bypass allocation and for evicted lines. Each slot has its own "blocked" flag, which stalls the cache while the slot is occupied, and its own bus-request flag, which stays up until the entry has been handed to the memory bus.

A miss request is sorted by kind. A write that is uncacheable, arrives while write-allocate is off, or expects no response goes to the writeback slot. Every other miss goes to the miss slot and, when cacheable, is marked as a line fill. Its bus command is then shown as a fill while the original command is kept for the response. A single bus offer picks the miss slot first. An issue handshake either releases the entry at once (no response expected) or marks it in service until a tagged response arrives. A response either completes a line fill or forwards data to the one waiting target. A thread squash cancels the miss slot's target and drops the entry if it has not been issued. Eviction writebacks load the writeback slot directly and count up a writeback counter. The line payload is carried as an opaque register.

Top module: `blk_miss_buffer`

## Requirements
- R1: A synchronous active-high reset empties both slots and clears blk_no_miss, blk_no_wb, busreq_miss, busreq_wb, bus_valid and wb_count.
- R2: Every stored address is the incoming address with its low log2(LINE_BYTES) bits forced to zero, and it appears on bus_addr when that slot is offered.
- R3: An accepted write with req_uncached=1, cfg_wr_alloc=0 or req_need_resp=0 enters the writeback slot and raises blk_no_wb and busreq_wb on the next cycle. It is offered with bus_cmd WRITE (1).
- R4: Any other accepted miss enters the miss slot and raises blk_no_miss and busreq_miss. bus_cmd reads FILL (3) when the request was cacheable and otherwise reads the original command, READ (0) or WRITE (1). tgt_cmd shows the original command during a response.
- R5: bus_sel is 0 (miss slot) whenever the miss slot is valid and not in service. Otherwise the writeback slot is selected (bus_sel 1). bus_valid equals the selected slot's request flag.
- R6: bus_issue while bus_valid clears the selected slot's request flag. If bus_need_resp is 0, the slot is freed and its blocked flag falls. Otherwise the blocked flag stays up while the entry is in service.
- R7: A response (resp_tag 0) to an in-service line-fill entry frees the miss slot, drops blk_no_miss and leaves tgt_valid at 0.
- R8: A response to a non-fill in-service entry that still has its target raises tgt_valid for that cycle with the entry's thread. tgt_data equals resp_data for a READ and zero for any other command. The slot named by resp_tag is then freed.
- R9: squash_valid with a thread equal to the miss slot's thread removes its target. If the entry has not been issued, blk_no_miss and busreq_miss fall on the next cycle. A squash for another thread has no effect.
- R10: An accepted eviction loads the writeback slot with command WRITEBACK (2), no response expected and the given compressed flag, raises blk_no_wb and busreq_wb, and increments wb_count.
- R11: req_stall is high when the request's target slot is occupied, and such a request is not taken. evict_stall is high while the writeback slot is occupied or while a writeback-bound request is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_alloc | input | 1 | Write-allocate enable |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | Request is a write |
| req_uncached | input | 1 | Request is uncacheable |
| req_need_resp | input | 1 | Request expects a response |
| req_thread | input | THR_W | Requesting thread |
| req_data | input | LINE_W | Write payload |
| req_stall | output | 1 | Request refused, target slot busy |
| evict_valid | input | 1 | Eviction writeback present |
| evict_addr | input | ADDR_W | Evicted line address |
| evict_data | input | LINE_W | Evicted line payload |
| evict_compressed | input | 1 | Payload is compressed |
| evict_stall | output | 1 | Eviction refused |
| squash_valid | input | 1 | Thread squash |
| squash_thread | input | THR_W | Thread being squashed |
| blk_no_miss | output | 1 | Blocked: miss slot occupied |
| blk_no_wb | output | 1 | Blocked: writeback slot occupied |
| busreq_miss | output | 1 | Miss slot requests the bus |
| busreq_wb | output | 1 | Writeback slot requests the bus |
| bus_valid | output | 1 | An entry is offered to the bus |
| bus_sel | output | 1 | Offered slot, 0 miss, 1 writeback |
| bus_addr | output | ADDR_W | Offered line address |
| bus_cmd | output | 2 | Offered command: 0 READ, 1 WRITE, 2 WRITEBACK, 3 FILL |
| bus_need_resp | output | 1 | Offered entry expects a response |
| bus_compressed | output | 1 | Offered payload is compressed |
| bus_data | output | LINE_W | Offered payload |
| bus_issue | input | 1 | Bus takes the offered entry |
| resp_valid | input | 1 | Response present |
| resp_tag | input | 1 | Responding slot, 0 miss, 1 writeback |
| resp_data | input | LINE_W | Response payload |
| tgt_valid | output | 1 | Response forwarded to target |
| tgt_thread | output | THR_W | Target thread |
| tgt_cmd | output | 2 | Restored original command |
| tgt_data | output | LINE_W | Forwarded data |
| wb_count | output | CNT_W | Eviction writeback counter |

## Verification
The assertions check the invariants that hold on every cycle. A raised request flag always has its blocked flag with it, a pending miss always wins the bus offer, and a forward never occurs without a response. They also check the one-cycle consequences of handshakes: an issue clears the request flag, an issue without a response releases the slot, a miss response frees the slot, an unissued matching squash frees the slot, and an eviction bumps the counter. The value-level behaviour can only be shown by the bench's scenarios. This covers address alignment, how each kind of write is sorted, the fill command and the restored original command, zeroed data for non-read forwards, the swallowed target after a squash of an issued miss, and stalls on simultaneous writeback-bound traffic.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;
   localparam logic [1:0] CMD_READ      = 2'd0;
   localparam logic [1:0] CMD_WRITE     = 2'd1;
   localparam logic [1:0] CMD_WRITEBACK = 2'd2;
   localparam logic [1:0] CMD_FILL      = 2'd3;
   localparam logic       SLOT_MISS     = 1'b0;
   localparam logic       SLOT_WB       = 1'b1;
   localparam int         NUM_SLOTS     = 2;
endpackage

// File: rtl/mbuf_slot.sv
module mbuf_slot #(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 64,
   parameter int THR_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              alloc_i,
   input  logic [ADDR_W-1:0] a_addr_i,
   input  logic [1:0]        a_cmd_i,
   input  logic              a_fill_i,
   input  logic              a_need_i,
   input  logic [THR_W-1:0]  a_thread_i,
   input  logic              a_comp_i,
   input  logic [LINE_W-1:0] a_data_i,
   input  logic              issue_i,
   input  logic              resp_free_i,
   input  logic              squash_hit_i,
   output logic              valid_o,
   output logic              insvc_o,
   output logic              blocked_o,
   output logic              busreq_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        cmd_o,
   output logic              fill_o,
   output logic              need_o,
   output logic              has_tgt_o,
   output logic [THR_W-1:0]  thread_o,
   output logic              comp_o,
   output logic [LINE_W-1:0] data_o
);
   logic valid_q, insvc_q, blocked_q, busreq_q, tgt_q, need_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q   <= 1'b0;
         insvc_q   <= 1'b0;
         blocked_q <= 1'b0;
         busreq_q  <= 1'b0;
         tgt_q     <= 1'b0;
      end else if (alloc_i) begin
         valid_q   <= 1'b1;
         insvc_q   <= 1'b0;
         blocked_q <= 1'b1;
         busreq_q  <= 1'b1;
         tgt_q     <= a_need_i;
      end else begin
         if (issue_i) begin
            busreq_q <= 1'b0;
            if (need_q) begin
               insvc_q <= 1'b1;
            end else begin
               valid_q   <= 1'b0;
               blocked_q <= 1'b0;
            end
         end
         if (resp_free_i) begin
            valid_q   <= 1'b0;
            insvc_q   <= 1'b0;
            blocked_q <= 1'b0;
            tgt_q     <= 1'b0;
         end
         if (squash_hit_i) begin
            tgt_q <= 1'b0;
            if (!insvc_q && !issue_i) begin
               valid_q   <= 1'b0;
               blocked_q <= 1'b0;
               busreq_q  <= 1'b0;
            end
         end
      end
   end

   // payload is only meaningful while valid, so it carries no reset
   always_ff @(posedge clk) begin
      if (alloc_i) begin
         addr_o   <= a_addr_i;
         cmd_o    <= a_cmd_i;
         fill_o   <= a_fill_i;
         need_q   <= a_need_i;
         thread_o <= a_thread_i;
         comp_o   <= a_comp_i;
         data_o   <= a_data_i;
      end
   end

   assign valid_o   = valid_q;
   assign insvc_o   = insvc_q;
   assign blocked_o = blocked_q;
   assign busreq_o  = busreq_q;
   assign has_tgt_o = tgt_q;
   assign need_o    = need_q;
endmodule

// File: rtl/mbuf_arb.sv
module mbuf_arb
   import mbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 64
) (
   input  logic              miss_valid_i,
   input  logic              miss_insvc_i,
   input  logic              busreq_i [NUM_SLOTS],
   input  logic [ADDR_W-1:0] addr_i   [NUM_SLOTS],
   input  logic [1:0]        cmd_i    [NUM_SLOTS],
   input  logic              fill_i   [NUM_SLOTS],
   input  logic              need_i   [NUM_SLOTS],
   input  logic              comp_i   [NUM_SLOTS],
   input  logic [LINE_W-1:0] data_i   [NUM_SLOTS],
   input  logic              bus_issue_i,
   output logic              bus_valid_o,
   output logic              bus_sel_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [1:0]        bus_cmd_o,
   output logic              bus_need_o,
   output logic              bus_comp_o,
   output logic [LINE_W-1:0] bus_data_o,
   output logic              issue_o  [NUM_SLOTS]
);
   logic sel;

   always_comb begin
      sel         = (miss_valid_i && !miss_insvc_i) ? SLOT_MISS : SLOT_WB;
      bus_sel_o   = sel;
      bus_valid_o = busreq_i[sel];
      bus_addr_o  = addr_i[sel];
      bus_cmd_o   = fill_i[sel] ? CMD_FILL : cmd_i[sel];
      bus_need_o  = need_i[sel];
      bus_comp_o  = comp_i[sel];
      bus_data_o  = data_i[sel];
      for (int i = 0; i < NUM_SLOTS; i++) begin
         issue_o[i] = bus_issue_i && bus_valid_o && (sel == 1'(i));
      end
   end
endmodule

// File: rtl/mbuf_resp.sv
module mbuf_resp
   import mbuf_pkg::*;
#(
   parameter int LINE_W = 64,
   parameter int THR_W  = 2
) (
   input  logic              resp_valid_i,
   input  logic              resp_tag_i,
   input  logic [LINE_W-1:0] resp_data_i,
   input  logic              valid_i   [NUM_SLOTS],
   input  logic              insvc_i   [NUM_SLOTS],
   input  logic              fill_i    [NUM_SLOTS],
   input  logic              has_tgt_i [NUM_SLOTS],
   input  logic [THR_W-1:0]  thread_i  [NUM_SLOTS],
   input  logic [1:0]        cmd_i     [NUM_SLOTS],
   output logic              free_o    [NUM_SLOTS],
   output logic              tgt_valid_o,
   output logic [THR_W-1:0]  tgt_thread_o,
   output logic [1:0]        tgt_cmd_o,
   output logic [LINE_W-1:0] tgt_data_o
);
   logic hit;

   always_comb begin
      hit          = resp_valid_i && valid_i[resp_tag_i] && insvc_i[resp_tag_i];
      tgt_valid_o  = hit && !fill_i[resp_tag_i] && has_tgt_i[resp_tag_i];
      tgt_thread_o = thread_i[resp_tag_i];
      tgt_cmd_o    = cmd_i[resp_tag_i];
      tgt_data_o   = (tgt_valid_o && cmd_i[resp_tag_i] == CMD_READ) ? resp_data_i : '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         free_o[i] = hit && (resp_tag_i == 1'(i));
      end
   end
endmodule

// File: rtl/blk_miss_buffer.sv
module blk_miss_buffer
   import mbuf_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LINE_BYTES   = 16,
   parameter int LINE_W       = 64,
   parameter int THR_W        = 2,
   parameter int CNT_W        = 8,
   parameter bit CNT_SATURATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr_alloc,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_uncached,
   input  logic              req_need_resp,
   input  logic [THR_W-1:0]  req_thread,
   input  logic [LINE_W-1:0] req_data,
   output logic              req_stall,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic [LINE_W-1:0] evict_data,
   input  logic              evict_compressed,
   output logic              evict_stall,
   input  logic              squash_valid,
   input  logic [THR_W-1:0]  squash_thread,
   output logic              blk_no_miss,
   output logic              blk_no_wb,
   output logic              busreq_miss,
   output logic              busreq_wb,
   output logic              bus_valid,
   output logic              bus_sel,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_cmd,
   output logic              bus_need_resp,
   output logic              bus_compressed,
   output logic [LINE_W-1:0] bus_data,
   input  logic              bus_issue,
   input  logic              resp_valid,
   input  logic              resp_tag,
   input  logic [LINE_W-1:0] resp_data,
   output logic              tgt_valid,
   output logic [THR_W-1:0]  tgt_thread,
   output logic [1:0]        tgt_cmd,
   output logic [LINE_W-1:0] tgt_data,
   output logic [CNT_W-1:0]  wb_count
);
   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W < 2 || LINE_W < 1 || THR_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   // per-slot state
   logic              s_alloc  [NUM_SLOTS];
   logic [ADDR_W-1:0] s_a_addr [NUM_SLOTS];
   logic [1:0]        s_a_cmd  [NUM_SLOTS];
   logic              s_a_fill [NUM_SLOTS];
   logic              s_a_need [NUM_SLOTS];
   logic [THR_W-1:0]  s_a_thr  [NUM_SLOTS];
   logic              s_a_comp [NUM_SLOTS];
   logic [LINE_W-1:0] s_a_data [NUM_SLOTS];
   logic              s_issue  [NUM_SLOTS];
   logic              s_free   [NUM_SLOTS];
   logic              s_squash [NUM_SLOTS];
   logic              s_valid  [NUM_SLOTS];
   logic              s_insvc  [NUM_SLOTS];
   logic              s_block  [NUM_SLOTS];
   logic              s_busreq [NUM_SLOTS];
   logic [ADDR_W-1:0] s_addr   [NUM_SLOTS];
   logic [1:0]        s_cmd    [NUM_SLOTS];
   logic              s_fill   [NUM_SLOTS];
   logic              s_need   [NUM_SLOTS];
   logic              s_tgt    [NUM_SLOTS];
   logic [THR_W-1:0]  s_thread [NUM_SLOTS];
   logic              s_comp   [NUM_SLOTS];
   logic [LINE_W-1:0] s_data   [NUM_SLOTS];

   logic              to_wb, req_acc, evict_acc, wb_from_req;
   logic [ADDR_W-1:0] req_line, evict_line;
   logic [THR_W-1:0]  miss_thread;

   // request sorting and admission
   always_comb begin
      to_wb       = req_write && (req_uncached || !cfg_wr_alloc || !req_need_resp);
      req_stall   = to_wb ? s_valid[SLOT_WB] : s_valid[SLOT_MISS];
      req_acc     = req_valid && !req_stall;
      wb_from_req = req_acc && to_wb;
      evict_stall = s_valid[SLOT_WB] || (req_valid && to_wb);
      evict_acc   = evict_valid && !evict_stall;
      req_line    = req_addr & ~OFF_MASK;
      evict_line  = evict_addr & ~OFF_MASK;
   end

   always_comb begin
      s_alloc[SLOT_MISS]  = req_acc && !to_wb;
      s_a_addr[SLOT_MISS] = req_line;
      s_a_cmd[SLOT_MISS]  = req_write ? CMD_WRITE : CMD_READ;
      s_a_fill[SLOT_MISS] = !req_uncached;
      s_a_need[SLOT_MISS] = req_need_resp;
      s_a_thr[SLOT_MISS]  = req_thread;
      s_a_comp[SLOT_MISS] = 1'b0;
      s_a_data[SLOT_MISS] = req_data;

      s_alloc[SLOT_WB]  = wb_from_req || evict_acc;
      s_a_addr[SLOT_WB] = wb_from_req ? req_line : evict_line;
      s_a_cmd[SLOT_WB]  = wb_from_req ? CMD_WRITE : CMD_WRITEBACK;
      s_a_fill[SLOT_WB] = 1'b0;
      s_a_need[SLOT_WB] = wb_from_req && req_need_resp;
      s_a_thr[SLOT_WB]  = wb_from_req ? req_thread : '0;
      s_a_comp[SLOT_WB] = !wb_from_req && evict_compressed;
      s_a_data[SLOT_WB] = wb_from_req ? req_data : evict_data;

      s_squash[SLOT_MISS] = squash_valid && s_valid[SLOT_MISS]
                            && (s_thread[SLOT_MISS] == squash_thread);
      s_squash[SLOT_WB]   = 1'b0;
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      mbuf_slot #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .THR_W(THR_W)) slot_i (
         .clk         (clk),
         .rst         (rst),
         .alloc_i     (s_alloc[g]),
         .a_addr_i    (s_a_addr[g]),
         .a_cmd_i     (s_a_cmd[g]),
         .a_fill_i    (s_a_fill[g]),
         .a_need_i    (s_a_need[g]),
         .a_thread_i  (s_a_thr[g]),
         .a_comp_i    (s_a_comp[g]),
         .a_data_i    (s_a_data[g]),
         .issue_i     (s_issue[g]),
         .resp_free_i (s_free[g]),
         .squash_hit_i(s_squash[g]),
         .valid_o     (s_valid[g]),
         .insvc_o     (s_insvc[g]),
         .blocked_o   (s_block[g]),
         .busreq_o    (s_busreq[g]),
         .addr_o      (s_addr[g]),
         .cmd_o       (s_cmd[g]),
         .fill_o      (s_fill[g]),
         .need_o      (s_need[g]),
         .has_tgt_o   (s_tgt[g]),
         .thread_o    (s_thread[g]),
         .comp_o      (s_comp[g]),
         .data_o      (s_data[g])
      );
   end

   mbuf_arb #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) arb_i (
      .miss_valid_i(s_valid[SLOT_MISS]),
      .miss_insvc_i(s_insvc[SLOT_MISS]),
      .busreq_i    (s_busreq),
      .addr_i      (s_addr),
      .cmd_i       (s_cmd),
      .fill_i      (s_fill),
      .need_i      (s_need),
      .comp_i      (s_comp),
      .data_i      (s_data),
      .bus_issue_i (bus_issue),
      .bus_valid_o (bus_valid),
      .bus_sel_o   (bus_sel),
      .bus_addr_o  (bus_addr),
      .bus_cmd_o   (bus_cmd),
      .bus_need_o  (bus_need_resp),
      .bus_comp_o  (bus_compressed),
      .bus_data_o  (bus_data),
      .issue_o     (s_issue)
   );

   mbuf_resp #(.LINE_W(LINE_W), .THR_W(THR_W)) resp_i (
      .resp_valid_i(resp_valid),
      .resp_tag_i  (resp_tag),
      .resp_data_i (resp_data),
      .valid_i     (s_valid),
      .insvc_i     (s_insvc),
      .fill_i      (s_fill),
      .has_tgt_i   (s_tgt),
      .thread_i    (s_thread),
      .cmd_i       (s_cmd),
      .free_o      (s_free),
      .tgt_valid_o (tgt_valid),
      .tgt_thread_o(tgt_thread),
      .tgt_cmd_o   (tgt_cmd),
      .tgt_data_o  (tgt_data)
   );

   if (CNT_SATURATE) begin : g_cnt_sat
      always_ff @(posedge clk) begin
         if (rst) wb_count <= '0;
         else if (evict_acc && !(&wb_count)) wb_count <= wb_count + 1'b1;
      end
   end else begin : g_cnt_wrap
      always_ff @(posedge clk) begin
         if (rst) wb_count <= '0;
         else if (evict_acc) wb_count <= wb_count + 1'b1;
      end
   end

   assign blk_no_miss = s_block[SLOT_MISS];
   assign blk_no_wb   = s_block[SLOT_WB];
   assign busreq_miss = s_busreq[SLOT_MISS];
   assign busreq_wb   = s_busreq[SLOT_WB];
   assign miss_thread = s_thread[SLOT_MISS];
endmodule

// File: rtl/mbuf_checker.sv
module mbuf_checker #(
   parameter int THR_W = 2,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             req_stall,
   input logic             evict_valid,
   input logic             evict_stall,
   input logic             squash_valid,
   input logic [THR_W-1:0] squash_thread,
   input logic [THR_W-1:0] miss_thread,
   input logic             blk_no_miss,
   input logic             blk_no_wb,
   input logic             busreq_miss,
   input logic             busreq_wb,
   input logic             bus_valid,
   input logic             bus_sel,
   input logic             bus_issue,
   input logic             bus_need_resp,
   input logic             resp_valid,
   input logic             resp_tag,
   input logic             tgt_valid,
   input logic [CNT_W-1:0] wb_count
);
   assert_miss_req_blocked_R6: assert property (@(posedge clk) disable iff (rst)
      busreq_miss |-> blk_no_miss);
   assert_wb_req_blocked_R6: assert property (@(posedge clk) disable iff (rst)
      busreq_wb |-> blk_no_wb);
   assert_miss_first_R5: assert property (@(posedge clk) disable iff (rst)
      busreq_miss |-> (bus_valid && bus_sel == 1'b0));
   assert_issue_clears_req_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_issue && bus_sel == 1'b0) |=> !busreq_miss);
   assert_noresp_release_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_issue && !bus_need_resp && bus_sel == 1'b1) |=> !blk_no_wb);
   assert_miss_resp_frees_R7: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_tag == 1'b0 && blk_no_miss && !busreq_miss) |=> !blk_no_miss);
   assert_fwd_needs_resp_R8: assert property (@(posedge clk) disable iff (rst)
      tgt_valid |-> resp_valid);
   assert_squash_frees_R9: assert property (@(posedge clk) disable iff (rst)
      (squash_valid && squash_thread == miss_thread && busreq_miss && !bus_issue)
      |=> !blk_no_miss);
   assert_evict_counts_R10: assert property (@(posedge clk) disable iff (rst)
      (evict_valid && !evict_stall) |=> (blk_no_wb && busreq_wb &&
      (wb_count == CNT_W'($past(wb_count) + 1'b1) || (&$past(wb_count)))));
   assert_miss_only_on_accept_R11: assert property (@(posedge clk) disable iff (rst)
      $rose(blk_no_miss) |-> $past(req_valid && !req_stall));
   assert_evict_stall_busy_R11: assert property (@(posedge clk) disable iff (rst)
      blk_no_wb |-> evict_stall);
endmodule

bind blk_miss_buffer mbuf_checker #(.THR_W(THR_W), .CNT_W(CNT_W)) chk_i (
   .clk          (clk),
   .rst          (rst),
   .req_valid    (req_valid),
   .req_stall    (req_stall),
   .evict_valid  (evict_valid),
   .evict_stall  (evict_stall),
   .squash_valid (squash_valid),
   .squash_thread(squash_thread),
   .miss_thread  (miss_thread),
   .blk_no_miss  (blk_no_miss),
   .blk_no_wb    (blk_no_wb),
   .busreq_miss  (busreq_miss),
   .busreq_wb    (busreq_wb),
   .bus_valid    (bus_valid),
   .bus_sel      (bus_sel),
   .bus_issue    (bus_issue),
   .bus_need_resp(bus_need_resp),
   .resp_valid   (resp_valid),
   .resp_tag     (resp_tag),
   .tgt_valid    (tgt_valid),
   .wb_count     (wb_count)
);

// File: tb/blk_miss_buffer_tb_top.sv
module blk_miss_buffer_tb_top;
   localparam int ADDR_W = 32;
   localparam int LINE_W = 64;
   localparam int THR_W  = 2;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cfg_wr_alloc = 1'b1;
   logic              req_valid = 1'b0, req_write = 1'b0, req_uncached = 1'b0, req_need_resp = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [THR_W-1:0]  req_thread = '0;
   logic [LINE_W-1:0] req_data = '0;
   logic              req_stall;
   logic              evict_valid = 1'b0, evict_compressed = 1'b0;
   logic [ADDR_W-1:0] evict_addr = '0;
   logic [LINE_W-1:0] evict_data = '0;
   logic              evict_stall;
   logic              squash_valid = 1'b0;
   logic [THR_W-1:0]  squash_thread = '0;
   logic              blk_no_miss, blk_no_wb, busreq_miss, busreq_wb;
   logic              bus_valid, bus_sel, bus_need_resp, bus_compressed;
   logic [ADDR_W-1:0] bus_addr;
   logic [1:0]        bus_cmd;
   logic [LINE_W-1:0] bus_data;
   logic              bus_issue = 1'b0;
   logic              resp_valid = 1'b0, resp_tag = 1'b0;
   logic [LINE_W-1:0] resp_data = '0;
   logic              tgt_valid;
   logic [THR_W-1:0]  tgt_thread;
   logic [1:0]        tgt_cmd;
   logic [LINE_W-1:0] tgt_data;
   logic [CNT_W-1:0]  wb_count;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   blk_miss_buffer #(.ADDR_W(ADDR_W), .LINE_BYTES(16), .LINE_W(LINE_W),
                     .THR_W(THR_W), .CNT_W(CNT_W)) dut_i (.*);

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      req_valid = 0; evict_valid = 0; squash_valid = 0; bus_issue = 0; resp_valid = 0;
   endtask

   task automatic send_req(input logic [31:0] a, input logic wr, input logic unc,
                           input logic need, input logic [1:0] thr, input logic [63:0] d);
      @(negedge clk);
      idle();
      req_valid = 1; req_addr = a; req_write = wr; req_uncached = unc;
      req_need_resp = need; req_thread = thr; req_data = d;
   endtask

   task automatic issue();
      @(negedge clk); idle(); bus_issue = 1;
   endtask

   task automatic respond(input logic tag, input logic [63:0] d);
      @(negedge clk); idle(); resp_valid = 1; resp_tag = tag; resp_data = d;
   endtask

   task automatic settle();
      @(negedge clk); idle();
   endtask

   task automatic t_reset();
      check("R1 blk_no_miss", 64'(blk_no_miss), 0);
      check("R1 blk_no_wb", 64'(blk_no_wb), 0);
      check("R1 busreq_miss", 64'(busreq_miss), 0);
      check("R1 busreq_wb", 64'(busreq_wb), 0);
      check("R1 bus_valid", 64'(bus_valid), 0);
      check("R1 wb_count", 64'(wb_count), 0);
   endtask

   task automatic t_fill_read();
      send_req(32'h1234_567B, 0, 0, 1, 1, 0);
      #1 check("R11 no stall when empty", 64'(req_stall), 0);
      settle();
      check("R4 blk_no_miss", 64'(blk_no_miss), 1);
      check("R4 busreq_miss", 64'(busreq_miss), 1);
      check("R4 no wb block", 64'(blk_no_wb), 0);
      check("R2 aligned addr", 64'(bus_addr), 64'h1234_5670);
      check("R4 fill cmd", 64'(bus_cmd), 3);
      check("R5 sel miss", 64'(bus_sel), 0);
      send_req(32'h0000_2000, 0, 0, 1, 0, 0);
      #1 check("R11 stall when miss busy", 64'(req_stall), 1);
      issue();
      settle();
      check("R6 busreq cleared", 64'(busreq_miss), 0);
      check("R6 blocked kept", 64'(blk_no_miss), 1);
      check("R6 nothing offered", 64'(bus_valid), 0);
      respond(0, 64'h55);
      #1 check("R7 no forward on fill", 64'(tgt_valid), 0);
      check("R4 restored read cmd", 64'(tgt_cmd), 0);
      settle();
      check("R7 miss freed", 64'(blk_no_miss), 0);
   endtask

   task automatic t_uncached_read();
      send_req(32'h0000_0104, 0, 1, 1, 2, 0);
      settle();
      check("R4 uncached cmd read", 64'(bus_cmd), 0);
      check("R2 uncached aligned", 64'(bus_addr), 64'h100);
      issue();
      respond(0, 64'hDEAD_BEEF_0123_4567);
      #1 check("R8 forward", 64'(tgt_valid), 1);
      check("R8 read data", tgt_data, 64'hDEAD_BEEF_0123_4567);
      check("R8 thread", 64'(tgt_thread), 2);
      settle();
      check("R8 slot freed", 64'(blk_no_miss), 0);
   endtask

   task automatic t_write_noresp();
      send_req(32'h0000_3333, 1, 0, 0, 0, 64'hA5);
      settle();
      check("R3 wb blocked", 64'(blk_no_wb), 1);
      check("R3 wb req", 64'(busreq_wb), 1);
      check("R3 miss untouched", 64'(blk_no_miss), 0);
      check("R3 sel wb", 64'(bus_sel), 1);
      check("R3 cmd write", 64'(bus_cmd), 1);
      check("R3 data", bus_data, 64'hA5);
      check("R6 no resp flag", 64'(bus_need_resp), 0);
      issue();
      settle();
      check("R6 released at issue", 64'(blk_no_wb), 0);
      check("R6 req cleared", 64'(busreq_wb), 0);
   endtask

   task automatic t_write_nalloc();
      cfg_wr_alloc = 0;
      send_req(32'h0000_4440, 1, 0, 1, 3, 64'h77);
      settle();
      cfg_wr_alloc = 1;
      check("R3 no-alloc write to wb", 64'(blk_no_wb), 1);
      check("R3 no-alloc miss idle", 64'(blk_no_miss), 0);
      issue();
      settle();
      check("R6 in service", 64'(blk_no_wb), 1);
      check("R6 req cleared wb", 64'(busreq_wb), 0);
      respond(1, 64'hFFFF);
      #1 check("R8 write forward", 64'(tgt_valid), 1);
      check("R8 write data zero", tgt_data, 0);
      check("R8 write cmd", 64'(tgt_cmd), 1);
      settle();
      check("R8 wb freed", 64'(blk_no_wb), 0);
      send_req(32'h0000_5000, 1, 1, 1, 0, 0);
      settle();
      check("R3 uncached write to wb", 64'(blk_no_wb), 1);
      check("R3 uncached write miss idle", 64'(blk_no_miss), 0);
      issue();
      respond(1, 0);
      settle();
      check("R8 uncached write freed", 64'(blk_no_wb), 0);
   endtask

   task automatic t_write_alloc();
      send_req(32'h0000_6008, 1, 0, 1, 1, 0);
      settle();
      check("R4 alloc write in miss", 64'(blk_no_miss), 1);
      check("R4 alloc write fill cmd", 64'(bus_cmd), 3);
      issue();
      respond(0, 64'h12);
      #1 check("R7 fill write no forward", 64'(tgt_valid), 0);
      check("R4 restored write cmd", 64'(tgt_cmd), 1);
      settle();
      check("R7 fill write freed", 64'(blk_no_miss), 0);
   endtask

   task automatic t_arb();
      send_req(32'h0000_7000, 1, 0, 0, 0, 0);
      send_req(32'h0000_8000, 0, 0, 1, 0, 0);
      settle();
      check("R5 both pending miss first", 64'(bus_sel), 0);
      check("R5 offer valid", 64'(bus_valid), 1);
      issue();
      settle();
      check("R5 wb after miss issued", 64'(bus_sel), 1);
      check("R5 wb offered", 64'(bus_valid), 1);
      issue();
      settle();
      check("R6 wb released", 64'(blk_no_wb), 0);
      respond(0, 0);
      settle();
      check("R7 arb miss freed", 64'(blk_no_miss), 0);
   endtask

   task automatic t_squash();
      send_req(32'h0000_9000, 0, 0, 1, 1, 0);
      @(negedge clk); idle(); squash_valid = 1; squash_thread = 2;
      settle();
      check("R9 other thread ignored", 64'(blk_no_miss), 1);
      check("R9 other thread req kept", 64'(busreq_miss), 1);
      @(negedge clk); idle(); squash_valid = 1; squash_thread = 1;
      settle();
      check("R9 unissued freed", 64'(blk_no_miss), 0);
      check("R9 req cleared", 64'(busreq_miss), 0);
      check("R9 nothing offered", 64'(bus_valid), 0);
      send_req(32'h0000_A000, 0, 1, 1, 3, 0);
      issue();
      @(negedge clk); idle(); squash_valid = 1; squash_thread = 3;
      settle();
      check("R9 issued stays", 64'(blk_no_miss), 1);
      respond(0, 64'h99);
      #1 check("R9 target dropped", 64'(tgt_valid), 0);
      settle();
      check("R9 freed by response", 64'(blk_no_miss), 0);
   endtask

   task automatic t_evict();
      @(negedge clk); idle();
      evict_valid = 1; evict_addr = 32'h0000_ABCF; evict_data = 64'hC0FFEE; evict_compressed = 1;
      #1 check("R11 evict accepted", 64'(evict_stall), 0);
      settle();
      check("R10 count", 64'(wb_count), 1);
      check("R10 blocked", 64'(blk_no_wb), 1);
      check("R10 req", 64'(busreq_wb), 1);
      check("R10 addr", 64'(bus_addr), 64'hABC0);
      check("R10 cmd", 64'(bus_cmd), 2);
      check("R10 compressed", 64'(bus_compressed), 1);
      check("R10 no resp", 64'(bus_need_resp), 0);
      check("R10 data", bus_data, 64'hC0FFEE);
      @(negedge clk); idle(); evict_valid = 1;
      #1 check("R11 evict stall busy", 64'(evict_stall), 1);
      settle();
      check("R11 count unchanged", 64'(wb_count), 1);
      issue();
      settle();
      check("R6 evict released", 64'(blk_no_wb), 0);
      send_req(32'h0000_B000, 1, 0, 0, 0, 0);
      evict_valid = 1;
      #1 check("R11 evict stall on wb request", 64'(evict_stall), 1);
      settle();
      check("R11 count kept on conflict", 64'(wb_count), 1);
      check("R11 request won slot", 64'(bus_cmd), 1);
      issue();
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_fill_read();
      t_uncached_read();
      t_write_noresp();
      t_write_nalloc();
      t_write_alloc();
      t_arb();
      t_squash();
      t_evict();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule